// File: doc/BRIEF.md
# Symmetric L2 descriptor matcher

This block pairs keypoints between two images. Software loads a reference list and an inspection list into internal buffers. Each entry holds a descriptor of `DIM` unsigned 8-bit elements and an (x, y) location. After a start pulse the block searches in both directions:

- Forward: for every reference entry it finds the inspection entry with the smallest squared Euclidean distance.
- Backward: for every inspection entry it finds the best reference entry.

In both directions a candidate is compared only when its x offset and its y offset from the query point both lie inside a square search window. Only mutual best pairs leave the block, as a stream of index pairs. A one-cycle done pulse closes each run.

Descriptors are read `LANES` elements per cycle. The store registers the next slice of both vectors while the distance unit accumulates the current slice, so that reading and accumulating overlap. The squared distance is kept exact and never square-rooted, so the ordering of candidates is the same as with true L2.

Top module: `sym_l2_matcher`

## Requirements
- R1: The distance between two entries is the exact sum over all `DIM` elements of (a-b)^2, for element values across the full range 0..255, with no wrap.
- R2: A candidate is compared only when |dx| <= `win_i` and |dy| <= `win_i`. Both bounds are inclusive and the window value is sampled at start.
- R3: A pair (r, s) is output only when inspection entry s is the best match of reference entry r, and reference entry r is also the best match of inspection entry s.
- R4: When two candidates have equal distance, the one with the lower list index is taken as the best.
- R5: An entry with no candidate inside its window has no best match, so it appears in no output pair.
- R6: Output pairs appear with strictly ascending reference index, at most one per cycle. `done_o` is a single-cycle pulse that is never high together with `match_valid_o`, and no pair follows it.
- R7: A `start_i` while idle makes `busy_o` high from the next cycle. `busy_o` stays high until the cycle in which `done_o` pulses, and is low in that cycle.
- R8: Descriptor writes carry `LANES` elements per word. Byte l of beat b holds element b*`LANES`+l of the entry selected by `wr_list_i` (0 = reference, 1 = inspection) and `wr_idx_i`. A location write stores x and y for that entry.
- R9: A run with either list count at zero ends with `done_o` and no output pair.
- R10: After reset, `busy_o`, `match_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one descriptor word |
| wr_list_i | input | 1 | List select: 0 reference, 1 inspection |
| wr_idx_i | input | IDX_W | Entry index |
| wr_beat_i | input | BEAT_W | Word index within the descriptor |
| wr_data_i | input | LANES*8 | Descriptor word, lane l in bits [8l+7:8l] |
| wr_loc_en_i | input | 1 | Write the entry location |
| wr_x_i | input | CW | Location x |
| wr_y_i | input | CW | Location y |
| start_i | input | 1 | Begin a matching run |
| n_ref_i | input | CNT_W | Reference entry count (0..MAX_N) |
| n_insp_i | input | CNT_W | Inspection entry count (0..MAX_N) |
| win_i | input | CW | Search half-window in pixels |
| busy_o | output | 1 | Run in progress |
| match_valid_o | output | 1 | Output pair valid |
| match_ref_o | output | IDX_W | Reference index of the pair |
| match_insp_o | output | IDX_W | Inspection index of the pair |
| done_o | output | 1 | Run finished, one-cycle pulse |

## Verification
The bench builds the block with `DIM`=8, `LANES`=4 (two beats per descriptor), `MAX_N`=8 and 10-bit coordinates. This keeps list loading short, so full eight-entry lists, exact window edges and random lists all fit in one short run. The two-beat descriptors exercise the clearing of the accumulator between candidates, and back-to-back candidate issue through the store's read stage. Directed cases cover ties, one-sided best matches, empty lists, keypoints with no candidate in their window and elements at 0 and 255. Random cases with random windows are compared against a behavioural model.

// File: rtl/sym_l2_pkg.sv
`timescale 1ns/1ps
package sym_l2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_EMIT  = 2'd3
  } mstate_e;

  localparam logic LIST_REF  = 1'b0;
  localparam logic LIST_INSP = 1'b1;
endpackage

// File: rtl/sym_l2_store.sv
`timescale 1ns/1ps
module sym_l2_store #(
  parameter int MAX_N  = 16,
  parameter int IDX_W  = 4,
  parameter int BEAT_W = 5,
  parameter int WORD_W = 32,
  parameter int CW     = 11
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic              wr_list_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BEAT_W-1:0] wr_beat_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_loc_en_i,
  input  logic [CW-1:0]     wr_x_i,
  input  logic [CW-1:0]     wr_y_i,
  input  logic              rd_en_i,
  input  logic              q_list_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic [BEAT_W-1:0] rd_beat_i,
  output logic [WORD_W-1:0] q_word_o,
  output logic [WORD_W-1:0] c_word_o,
  output logic [CW-1:0]     q_x_o,
  output logic [CW-1:0]     q_y_o,
  output logic [CW-1:0]     c_x_o,
  output logic [CW-1:0]     c_y_o
);
  localparam int AW    = 1 + IDX_W + BEAT_W;
  localparam int DEPTH = 2 ** AW;
  localparam int LW    = 1 + IDX_W;
  localparam int LDEP  = 2 ** LW;

  logic [WORD_W-1:0] mem   [DEPTH];
  logic [CW-1:0]     x_mem [LDEP];
  logic [CW-1:0]     y_mem [LDEP];

  logic [AW-1:0] wa, qa, ca;
  logic          c_list;

  assign c_list = ~q_list_i;
  assign wa = {wr_list_i, wr_idx_i, wr_beat_i};
  assign qa = {q_list_i, q_idx_i, rd_beat_i};
  assign ca = {c_list, c_idx_i, rd_beat_i};

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wa] <= wr_data_i;
    if (wr_loc_en_i) begin
      x_mem[{wr_list_i, wr_idx_i}] <= wr_x_i;
      y_mem[{wr_list_i, wr_idx_i}] <= wr_y_i;
    end
  end

  // registered read: next slice fetched while the current one accumulates
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      q_word_o <= mem[qa];
      c_word_o <= mem[ca];
    end
  end

  assign q_x_o = x_mem[{q_list_i, q_idx_i}];
  assign q_y_o = y_mem[{q_list_i, q_idx_i}];
  assign c_x_o = x_mem[{c_list, c_idx_i}];
  assign c_y_o = y_mem[{c_list, c_idx_i}];
endmodule

// File: rtl/sym_l2_dist.sv
`timescale 1ns/1ps
module sym_l2_dist #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int ACC_W = 23,
  parameter int TAG_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic                first_i,
  input  logic                last_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [LANES*EW-1:0] a_i,
  input  logic [LANES*EW-1:0] b_i,
  output logic                res_valid_o,
  output logic [ACC_W-1:0]    res_dist_o,
  output logic [TAG_W-1:0]    res_tag_o
);
  localparam int SQ_W = 2 * EW;

  logic [SQ_W-1:0]  sq [LANES];
  logic [ACC_W-1:0] lane_sum, acc_q, acc_base, acc_nx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] a, b, d;
    assign a = a_i[l*EW +: EW];
    assign b = b_i[l*EW +: EW];
    assign d = (a >= b) ? (a - b) : (b - a);
    assign sq[l] = {{EW{1'b0}}, d} * {{EW{1'b0}}, d};
  end

  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < LANES; l++) lane_sum = lane_sum + ACC_W'(sq[l]);
  end

  assign acc_base = first_i ? '0 : acc_q;
  assign acc_nx   = acc_base + lane_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      res_valid_o <= 1'b0;
      res_dist_o  <= '0;
      res_tag_o   <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (in_valid_i) begin
        acc_q <= acc_nx;
        if (last_i) begin
          res_valid_o <= 1'b1;
          res_dist_o  <= acc_nx;
          res_tag_o   <= tag_i;
        end
      end
    end
  end
endmodule

// File: rtl/sym_l2_ctrl.sv
`timescale 1ns/1ps
module sym_l2_ctrl
  import sym_l2_pkg::*;
#(
  parameter int MAX_N  = 16,
  parameter int BEATS  = 32,
  parameter int IDX_W  = 4,
  parameter int BEAT_W = 5,
  parameter int CNT_W  = 5,
  parameter int CW     = 11,
  parameter int ACC_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_ref_i,
  input  logic [CNT_W-1:0]  n_insp_i,
  input  logic [CW-1:0]     win_i,
  output logic              rd_en_o,
  output logic              q_list_o,
  output logic [IDX_W-1:0]  q_idx_o,
  output logic [IDX_W-1:0]  c_idx_o,
  output logic [BEAT_W-1:0] rd_beat_o,
  input  logic [CW-1:0]     q_x_i,
  input  logic [CW-1:0]     q_y_i,
  input  logic [CW-1:0]     c_x_i,
  input  logic [CW-1:0]     c_y_i,
  output logic              iss_valid_o,
  output logic              iss_first_o,
  output logic              iss_last_o,
  output logic [IDX_W-1:0]  iss_tag_o,
  input  logic              res_valid_i,
  input  logic [ACC_W-1:0]  res_dist_i,
  input  logic [IDX_W-1:0]  res_tag_i,
  output logic              busy_o,
  output logic              match_valid_o,
  output logic [IDX_W-1:0]  match_ref_o,
  output logic [IDX_W-1:0]  match_insp_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0]  ONE_C     = 1;
  localparam logic [BEAT_W-1:0] ONE_B     = 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  mstate_e           state;
  logic              pass;
  logic [CNT_W-1:0]  nref_q, ninsp_q, qi, ci, ei, nq, nc;
  logic [CW-1:0]     win_q, dx, dy;
  logic [BEAT_W-1:0] beat;
  logic              dcnt, in_win, issue, commit;

  logic              best_v;
  logic [ACC_W-1:0]  best_d;
  logic [IDX_W-1:0]  best_i;

  logic [MAX_N-1:0]  fwd_v, bwd_v;
  logic [IDX_W-1:0]  fwd_idx [MAX_N];
  logic [IDX_W-1:0]  bwd_idx [MAX_N];

  logic [IDX_W-1:0]  e_idx, e_fwd;
  logic              e_mutual;

  assign nq = pass ? ninsp_q : nref_q;
  assign nc = pass ? nref_q  : ninsp_q;

  assign dx = (q_x_i >= c_x_i) ? (q_x_i - c_x_i) : (c_x_i - q_x_i);
  assign dy = (q_y_i >= c_y_i) ? (q_y_i - c_y_i) : (c_y_i - q_y_i);
  assign in_win = (dx <= win_q) && (dy <= win_q);

  assign issue  = (state == ST_SCAN) && (qi != nq) && (ci != nc) &&
                  !((beat == '0) && !in_win);
  assign commit = (state == ST_DRAIN) && dcnt;

  assign rd_en_o   = issue;
  assign q_list_o  = pass;
  assign q_idx_o   = qi[IDX_W-1:0];
  assign c_idx_o   = ci[IDX_W-1:0];
  assign rd_beat_o = beat;
  assign busy_o    = (state != ST_IDLE);

  assign e_idx    = ei[IDX_W-1:0];
  assign e_fwd    = fwd_idx[e_idx];
  assign e_mutual = fwd_v[e_idx] && bwd_v[e_fwd] && (bwd_idx[e_fwd] == e_idx);

  // candidate issue flags travel one cycle alongside the store read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_valid_o <= 1'b0;
      iss_first_o <= 1'b0;
      iss_last_o  <= 1'b0;
      iss_tag_o   <= '0;
    end else begin
      iss_valid_o <= issue;
      iss_first_o <= (beat == '0);
      iss_last_o  <= (beat == LAST_BEAT);
      iss_tag_o   <= ci[IDX_W-1:0];
    end
  end

  // running best: candidates arrive in ascending index, strict compare keeps the lower on ties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_v <= 1'b0;
      best_d <= '0;
      best_i <= '0;
    end else if (commit || (state == ST_IDLE)) begin
      best_v <= 1'b0;
    end else if (res_valid_i && (!best_v || (res_dist_i < best_d))) begin
      best_v <= 1'b1;
      best_d <= res_dist_i;
      best_i <= res_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_v <= '0;
      bwd_v <= '0;
      for (int k = 0; k < MAX_N; k++) begin
        fwd_idx[k] <= '0;
        bwd_idx[k] <= '0;
      end
    end else if (commit) begin
      if (!pass) begin
        fwd_v[qi[IDX_W-1:0]]   <= best_v;
        fwd_idx[qi[IDX_W-1:0]] <= best_i;
      end else begin
        bwd_v[qi[IDX_W-1:0]]   <= best_v;
        bwd_idx[qi[IDX_W-1:0]] <= best_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_IDLE;
      pass          <= 1'b0;
      nref_q        <= '0;
      ninsp_q       <= '0;
      win_q         <= '0;
      qi            <= '0;
      ci            <= '0;
      ei            <= '0;
      beat          <= '0;
      dcnt          <= 1'b0;
      match_valid_o <= 1'b0;
      match_ref_o   <= '0;
      match_insp_o  <= '0;
      done_o        <= 1'b0;
    end else begin
      match_valid_o <= 1'b0;
      done_o        <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            nref_q  <= n_ref_i;
            ninsp_q <= n_insp_i;
            win_q   <= win_i;
            pass    <= 1'b0;
            qi      <= '0;
            ci      <= '0;
            beat    <= '0;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (qi == nq) begin
            if (!pass) begin
              pass <= 1'b1;
              qi   <= '0;
              ci   <= '0;
            end else begin
              ei    <= '0;
              state <= ST_EMIT;
            end
          end else if (ci == nc) begin
            dcnt  <= 1'b0;
            state <= ST_DRAIN;
          end else if ((beat == '0) && !in_win) begin
            ci <= ci + ONE_C;
          end else if (beat == LAST_BEAT) begin
            beat <= '0;
            ci   <= ci + ONE_C;
          end else begin
            beat <= beat + ONE_B;
          end
        end
        ST_DRAIN: begin
          if (!dcnt) begin
            dcnt <= 1'b1;
          end else begin
            qi    <= qi + ONE_C;
            ci    <= '0;
            state <= ST_SCAN;
          end
        end
        ST_EMIT: begin
          if (ei == nref_q) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            match_valid_o <= e_mutual;
            match_ref_o   <= e_idx;
            match_insp_o  <= e_fwd;
            ei            <= ei + ONE_C;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sym_l2_matcher.sv
`timescale 1ns/1ps
module sym_l2_matcher #(
  parameter int DIM   = 128,
  parameter int LANES = 4,
  parameter int MAX_N = 16,
  parameter int CW    = 11,
  localparam int EW     = 8,
  localparam int BEATS  = DIM / LANES,
  localparam int WORD_W = LANES * EW,
  localparam int IDX_W  = $clog2(MAX_N),
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CNT_W  = $clog2(MAX_N + 1),
  localparam int ACC_W  = 2 * EW + $clog2(DIM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_list_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BEAT_W-1:0] wr_beat_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_loc_en_i,
  input  logic [CW-1:0]     wr_x_i,
  input  logic [CW-1:0]     wr_y_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_ref_i,
  input  logic [CNT_W-1:0]  n_insp_i,
  input  logic [CW-1:0]     win_i,
  output logic              busy_o,
  output logic              match_valid_o,
  output logic [IDX_W-1:0]  match_ref_o,
  output logic [IDX_W-1:0]  match_insp_o,
  output logic              done_o
);
  logic              rd_en, q_list;
  logic [IDX_W-1:0]  q_idx, c_idx;
  logic [BEAT_W-1:0] rd_beat;
  logic [WORD_W-1:0] q_word, c_word;
  logic [CW-1:0]     q_x, q_y, c_x, c_y;
  logic              iss_valid, iss_first, iss_last;
  logic [IDX_W-1:0]  iss_tag, res_tag;
  logic              res_valid;
  logic [ACC_W-1:0]  res_dist;

  sym_l2_store #(
    .MAX_N(MAX_N), .IDX_W(IDX_W), .BEAT_W(BEAT_W), .WORD_W(WORD_W), .CW(CW)
  ) u_store (
    .clk_i      (clk_i),
    .wr_en_i    (wr_en_i),
    .wr_list_i  (wr_list_i),
    .wr_idx_i   (wr_idx_i),
    .wr_beat_i  (wr_beat_i),
    .wr_data_i  (wr_data_i),
    .wr_loc_en_i(wr_loc_en_i),
    .wr_x_i     (wr_x_i),
    .wr_y_i     (wr_y_i),
    .rd_en_i    (rd_en),
    .q_list_i   (q_list),
    .q_idx_i    (q_idx),
    .c_idx_i    (c_idx),
    .rd_beat_i  (rd_beat),
    .q_word_o   (q_word),
    .c_word_o   (c_word),
    .q_x_o      (q_x),
    .q_y_o      (q_y),
    .c_x_o      (c_x),
    .c_y_o      (c_y)
  );

  sym_l2_dist #(
    .LANES(LANES), .EW(EW), .ACC_W(ACC_W), .TAG_W(IDX_W)
  ) u_dist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (iss_valid),
    .first_i    (iss_first),
    .last_i     (iss_last),
    .tag_i      (iss_tag),
    .a_i        (q_word),
    .b_i        (c_word),
    .res_valid_o(res_valid),
    .res_dist_o (res_dist),
    .res_tag_o  (res_tag)
  );

  sym_l2_ctrl #(
    .MAX_N(MAX_N), .BEATS(BEATS), .IDX_W(IDX_W), .BEAT_W(BEAT_W),
    .CNT_W(CNT_W), .CW(CW), .ACC_W(ACC_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .n_ref_i      (n_ref_i),
    .n_insp_i     (n_insp_i),
    .win_i        (win_i),
    .rd_en_o      (rd_en),
    .q_list_o     (q_list),
    .q_idx_o      (q_idx),
    .c_idx_o      (c_idx),
    .rd_beat_o    (rd_beat),
    .q_x_i        (q_x),
    .q_y_i        (q_y),
    .c_x_i        (c_x),
    .c_y_i        (c_y),
    .iss_valid_o  (iss_valid),
    .iss_first_o  (iss_first),
    .iss_last_o   (iss_last),
    .iss_tag_o    (iss_tag),
    .res_valid_i  (res_valid),
    .res_dist_i   (res_dist),
    .res_tag_i    (res_tag),
    .busy_o       (busy_o),
    .match_valid_o(match_valid_o),
    .match_ref_o  (match_ref_o),
    .match_insp_o (match_insp_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/sym_l2_chk.sv
`timescale 1ns/1ps
module sym_l2_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             match_valid_o,
  input logic [IDX_W-1:0] match_ref_o,
  input logic             done_o
);
  logic             seen;
  logic [IDX_W-1:0] last_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen     <= 1'b0;
      last_ref <= '0;
    end else if (start_i && !busy_o) begin
      seen <= 1'b0;
    end else if (match_valid_o) begin
      seen     <= 1'b1;
      last_ref <= match_ref_o;
    end
  end

  // R7
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_o |-> (!done_o && busy_o));

  // R6
  ref_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_valid_o && seen) |-> (match_ref_o > last_ref));
endmodule

bind sym_l2_matcher sym_l2_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .match_valid_o(match_valid_o),
  .match_ref_o  (match_ref_o),
  .done_o       (done_o)
);

// File: tb/sim_sym_l2_matcher.sv
`timescale 1ns/1ps
module sim_sym_l2_matcher;
  localparam int DIM    = 8;
  localparam int LANES  = 4;
  localparam int MAX_N  = 8;
  localparam int CW     = 10;
  localparam int BEATS  = DIM / LANES;
  localparam int IDX_W  = 3;
  localparam int BEAT_W = 1;
  localparam int CNT_W  = 4;
  localparam int WORD_W = LANES * 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0, wr_list_i = 1'b0, wr_loc_en_i = 1'b0;
  logic [IDX_W-1:0]  wr_idx_i = '0;
  logic [BEAT_W-1:0] wr_beat_i = '0;
  logic [WORD_W-1:0] wr_data_i = '0;
  logic [CW-1:0]     wr_x_i = '0, wr_y_i = '0, win_i = '0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  n_ref_i = '0, n_insp_i = '0;
  logic              busy_o, match_valid_o, done_o;
  logic [IDX_W-1:0]  match_ref_o, match_insp_o;

  sym_l2_matcher #(.DIM(DIM), .LANES(LANES), .MAX_N(MAX_N), .CW(CW)) u0 (.*);

  always #5 clk_i = ~clk_i;

  int desc [2][MAX_N][DIM];
  int px   [2][MAX_N];
  int py   [2][MAX_N];
  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int l2(input int r, input int s);
    int sum = 0;
    for (int e = 0; e < DIM; e++) sum += (desc[0][r][e] - desc[1][s][e]) ** 2;
    return sum;
  endfunction

  function automatic bit in_win(input int r, input int s, input int w);
    int dx = px[0][r] - px[1][s];
    int dy = py[0][r] - py[1][s];
    if (dx < 0) dx = -dx;
    if (dy < 0) dy = -dy;
    return (dx <= w) && (dy <= w);
  endfunction

  // R8: byte l of beat b carries element b*LANES+l
  task automatic load(input int nr, input int ni);
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < ((l == 0) ? nr : ni); i++) begin
        for (int b = 0; b < BEATS; b++) begin
          @(negedge clk_i);
          wr_en_i   = 1'b1;
          wr_list_i = l[0];
          wr_idx_i  = IDX_W'(i);
          wr_beat_i = BEAT_W'(b);
          for (int k = 0; k < LANES; k++)
            wr_data_i[k*8 +: 8] = 8'(desc[l][i][b*LANES + k]);
        end
        @(negedge clk_i);
        wr_en_i     = 1'b0;
        wr_loc_en_i = 1'b1;
        wr_x_i      = CW'(px[l][i]);
        wr_y_i      = CW'(py[l][i]);
      end
    end
    @(negedge clk_i);
    wr_en_i     = 1'b0;
    wr_loc_en_i = 1'b0;
  endtask

  task automatic run_case(input string tag, input int nr, input int ni, input int w);
    int fwd [MAX_N];
    int bwd [MAX_N];
    int expq[$];
    int cyc = 0;
    bit got_done = 0;
    for (int i = 0; i < nr; i++) begin
      int bd = 0;
      fwd[i] = -1;
      for (int j = 0; j < ni; j++)
        if (in_win(i, j, w) && (fwd[i] < 0 || l2(i, j) < bd)) begin
          fwd[i] = j;
          bd = l2(i, j);
        end
    end
    for (int j = 0; j < ni; j++) begin
      int bd = 0;
      bwd[j] = -1;
      for (int i = 0; i < nr; i++)
        if (in_win(i, j, w) && (bwd[j] < 0 || l2(i, j) < bd)) begin
          bwd[j] = i;
          bd = l2(i, j);
        end
    end
    for (int i = 0; i < nr; i++)
      if (fwd[i] >= 0 && bwd[fwd[i]] == i) expq.push_back(i * 16 + fwd[i]);

    load(nr, ni);
    @(negedge clk_i);
    start_i  = 1'b1;
    n_ref_i  = CNT_W'(nr);
    n_insp_i = CNT_W'(ni);
    win_i    = CW'(w);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R7 busy after start"}, int'(busy_o), 1);
    while (!got_done && cyc < 4000) begin
      @(negedge clk_i);
      cyc++;
      if (match_valid_o) begin
        if (expq.size() == 0) begin
          chk(1'b0, {tag, " R3 unexpected pair"}, int'(match_ref_o) * 16 + int'(match_insp_o), -1);
        end else begin
          int e = expq.pop_front();
          int g = int'(match_ref_o) * 16 + int'(match_insp_o);
          chk(g == e, {tag, " R3 R6 pair ref*16+insp"}, g, e);
        end
      end
      if (done_o) got_done = 1;
    end
    chk(got_done, {tag, " R7 done seen"}, int'(got_done), 1);
    chk(expq.size() == 0, {tag, " R5 pairs still expected"}, expq.size(), 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o && !match_valid_o, {tag, " R6 single done pulse"},
        int'(done_o) + int'(busy_o) + int'(match_valid_o), 0);
  endtask

  task automatic fill(input int l, input int i, input int v, input int x, input int y);
    for (int e = 0; e < DIM; e++) desc[l][i][e] = v;
    px[l][i] = x;
    py[l][i] = y;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10
    chk(!busy_o && !match_valid_o && !done_o, "R10 reset outputs",
        int'(busy_o) + int'(match_valid_o) + int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3: ramp descriptors, reversed order of pairing
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < DIM; e++) begin
        desc[0][i][e] = i * 40 + e * 3;
        desc[1][3-i][e] = i * 40 + e * 3 + ((e % 2 == 0) ? 2 : -1);
      end
      px[0][i] = 100; py[0][i] = 100; px[1][i] = 110; py[1][i] = 95;
    end
    run_case("basic", 4, 4, 50);

    // R3: ref1 prefers insp0 but insp0 prefers ref0
    fill(0, 0, 10, 50, 50);  fill(0, 1, 14, 50, 50);
    fill(1, 0, 11, 50, 50);  fill(1, 1, 200, 50, 50);
    run_case("one_sided", 2, 2, 30);

    // R2 R5: edge of window, outside window by one, ref with no candidate
    fill(0, 0, 80, 100, 100); fill(0, 1, 80, 500, 500);
    fill(1, 0, 81, 120, 80);  fill(1, 1, 80, 121, 100); fill(1, 2, 80, 100, 79);
    run_case("window_edge", 2, 3, 20);

    // R4: equal distance inspection candidates
    fill(0, 0, 50, 10, 10); fill(1, 0, 60, 10, 10); fill(1, 1, 40, 10, 10);
    run_case("tie_insp", 1, 2, 5);
    // R4: equal distance reference candidates
    fill(0, 0, 40, 10, 10); fill(0, 1, 60, 10, 10); fill(1, 0, 50, 10, 10);
    run_case("tie_ref", 2, 1, 5);

    // R1: full element range
    fill(0, 0, 0, 30, 30); fill(0, 1, 255, 30, 30);
    fill(1, 0, 255, 30, 30); fill(1, 1, 200, 30, 30);
    for (int e = 0; e < DIM; e += 2) desc[1][1][e] = 0;
    run_case("full_range", 2, 2, 10);

    // R9: empty lists
    run_case("empty_ref", 0, 3, 100);
    run_case("empty_insp", 3, 0, 100);

    // R1 R2 R8: random lists and windows
    for (int t = 0; t < 6; t++) begin
      int nr = $urandom_range(MAX_N, 1);
      int ni = $urandom_range(MAX_N, 1);
      for (int l = 0; l < 2; l++)
        for (int i = 0; i < MAX_N; i++) begin
          for (int e = 0; e < DIM; e++) desc[l][i][e] = $urandom_range(255, 0);
          px[l][i] = $urandom_range(299, 0);
          py[l][i] = $urandom_range(299, 0);
        end
      run_case("random", nr, ni, $urandom_range(150, 30));
    end

    // full lists, every candidate in window
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < MAX_N; i++) begin
        for (int e = 0; e < DIM; e++) desc[l][i][e] = $urandom_range(255, 0);
        px[l][i] = 5; py[l][i] = 5;
      end
    run_case("full_lists", MAX_N, MAX_N, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule